// File: doc/BRIEF.md
# On-Chip RAM Window Mapper

This block serves CPU loads and stores that fall inside a fixed 64 MiB address window, 0x7C000000 up to (but excluding) 0x80000000. When the operand cache is configured to give half of its data array to software as plain RAM, two 4 KiB pages of that array are addressed directly through the window. The block holds both pages, decodes the page and the offset from the address, and performs byte, word and longword accesses. Reads return sign-extended data one cycle later.

Three configuration bits control the window: a split-index bit, a RAM-enable bit and a cache-enable bit. The window is mapped only when RAM-enable and cache-enable are both set. The split-index bit then picks how the two pages tile the window. When it is clear, the pages alternate every 8 KiB on address bit 13. When it is set, the lower half of the window goes to page 0 and the upper half to page 1, which is the same as decoding on address bit 25. With any other bit combination, every access to the window is reported as unmapped.

Top module: `ocram_window`

## Requirements
- R1: Only addresses from 0x7C000000 to 0x7FFFFFFF are served. An access outside that range gives no read response and no error, and changes no stored byte.
- R2: The byte offset inside a page is address bits 11:0. Address bits that select neither the page nor the offset are ignored, so such addresses alias to the same location.
- R3: With cfg_index_split = 0, address bit 13 = 0 selects page 0 and bit 13 = 1 selects page 1.
- R4: With cfg_index_split = 1, addresses below 0x7E000000 select page 0 and the rest of the window selects page 1.
- R5: Unless cfg_ram_on and cfg_cache_on are both 1, a window access is unmapped. acc_err is high for exactly the cycle after the access. An unmapped read also raises rd_valid, with rd_data = 0. An unmapped write stores nothing.
- R6: A mapped read raises rd_valid for one cycle, in the cycle after acc_valid, and both rd_valid and acc_err are 0 after reset.
- R7: A byte read (acc_size = 0) returns the byte at lane offset[1:0], little-endian, sign-extended from bit 7.
- R8: A word read (acc_size = 1) ignores address bit 0, takes bytes offset and offset+1 little-endian, and sign-extends from bit 15.
- R9: A longword read (acc_size = 2, and 3 is treated the same way) ignores address bits 1:0 and returns all 32 bits.
- R10: A write stores only the access width at the offset: acc_wdata[7:0] for a byte, acc_wdata[15:0] for a word (bit 0 ignored), and all 32 bits for a longword (bits 1:0 ignored). The other bytes are left unchanged.
- R11: A read in the cycle after a write to the same location returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Byte address |
| acc_size | input | 2 | 0 byte, 1 word, 2 or 3 longword |
| acc_we | input | 1 | 1 write, 0 read |
| acc_wdata | input | 32 | Write data, right-justified |
| cfg_index_split | input | 1 | Page select by window half (1) or by address bit 13 (0) |
| cfg_ram_on | input | 1 | Cache RAM mode enable |
| cfg_cache_on | input | 1 | Operand cache enable |
| rd_valid | output | 1 | Read response strobe, one cycle after the read |
| rd_data | output | 32 | Sign-extended read data, zero when unmapped |
| acc_err | output | 1 | Unmapped-access strobe |

## Verification
The assertions assume that the configuration bits stay steady while an access is in flight, and that acc_addr, acc_size and acc_we are meaningful only when acc_valid is high. The stimulus changes the configuration only between accesses, always with acc_valid low on the intervening cycle, and it drives inputs only on the falling edge. Stored bytes have no reset value, so both pages are filled with known longwords before the first read, and the bench never reads a location that has not been written.

// File: rtl/ocram_pkg.sv
package ocram_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_LONG  = 2'd2,
    SZ_LONG3 = 2'd3
  } acc_size_e;

  // Byte-enable for an access of the given size at byte lane 'lane'.
  function automatic logic [3:0] f_lane_mask(input logic [1:0] size, input logic [1:0] lane);
    logic [3:0] m;
    case (size)
      SZ_BYTE: m = 4'b0001 << lane;
      SZ_WORD: m = lane[1] ? 4'b1100 : 4'b0011;
      default: m = 4'b1111;
    endcase
    return m;
  endfunction

  // Replicate the right-justified write data onto every lane it may occupy.
  function automatic logic [31:0] f_lane_data(input logic [1:0] size, input logic [31:0] wd);
    logic [31:0] d;
    case (size)
      SZ_BYTE: d = {4{wd[7:0]}};
      SZ_WORD: d = {2{wd[15:0]}};
      default: d = wd;
    endcase
    return d;
  endfunction

  // Pick the addressed bytes out of a stored word and sign-extend them.
  function automatic logic [31:0] f_extract(input logic [1:0] size, input logic [1:0] lane,
                                            input logic [31:0] w);
    logic [7:0]  b;
    logic [15:0] h;
    logic [31:0] r;
    b = w[8*lane +: 8];
    h = lane[1] ? w[31:16] : w[15:0];
    case (size)
      SZ_BYTE: r = {{24{b[7]}}, b};
      SZ_WORD: r = {{16{h[15]}}, h};
      default: r = w;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ocram_decode.sv
module ocram_decode #(
  parameter logic [32:0] WIN_BASE = 33'h0_7C00_0000,
  parameter logic [32:0] WIN_END  = 33'h0_8000_0000,
  parameter int unsigned ALT_BIT  = 13,
  parameter int unsigned OFF_W    = 12
) (
  input  logic [31:0]      addr,
  input  logic             index_split,
  input  logic             ram_on,
  input  logic             cache_on,
  output logic             in_window,
  output logic             mapped,
  output logic             page_sel,
  output logic [OFF_W-1:0] offset
);
  localparam logic [32:0] WIN_MID = (WIN_BASE + WIN_END) >> 1;

  logic [32:0] a_ext;
  assign a_ext = {1'b0, addr};

  always_comb begin
    in_window = (a_ext >= WIN_BASE) && (a_ext < WIN_END);
    mapped    = in_window && ram_on && cache_on;
    if (index_split) page_sel = (a_ext >= WIN_MID);
    else             page_sel = addr[ALT_BIT];
    offset    = addr[OFF_W-1:0];
  end
endmodule

// File: rtl/ocram_page_ram.sv
module ocram_page_ram #(
  parameter int unsigned WORDS = 1024,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [3:0]       be,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  input  logic             re,
  output logic [31:0]      rdata
);
  for (genvar ln = 0; ln < 4; ln++) begin : g_lane
    logic [7:0] store [WORDS];
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (we && be[ln]) store[idx] <= wdata[8*ln +: 8];
      if (re)           q <= store[idx];
    end
    assign rdata[8*ln +: 8] = q;
  end
endmodule

// File: rtl/ocram_rdfmt.sv
module ocram_rdfmt (
  input  logic [1:0]  size,
  input  logic [1:0]  lane,
  input  logic [31:0] word,
  input  logic        zero,
  output logic [31:0] data
);
  import ocram_pkg::*;
  always_comb begin
    if (zero) data = '0;
    else      data = f_extract(size, lane, word);
  end
endmodule

// File: rtl/ocram_window.sv
module ocram_window #(
  parameter logic [32:0] WIN_BASE   = 33'h0_7C00_0000,
  parameter logic [32:0] WIN_END    = 33'h0_8000_0000,
  parameter int unsigned PAGE_BYTES = 4096,
  parameter int unsigned ALT_BIT    = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic [31:0] acc_addr,
  input  logic [1:0]  acc_size,
  input  logic        acc_we,
  input  logic [31:0] acc_wdata,
  input  logic        cfg_index_split,
  input  logic        cfg_ram_on,
  input  logic        cfg_cache_on,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        acc_err
);
  import ocram_pkg::*;

  localparam int unsigned OFF_W  = $clog2(PAGE_BYTES);
  localparam int unsigned WORDS  = PAGE_BYTES / 4;
  localparam int unsigned IDX_W  = $clog2(WORDS);
  localparam int unsigned NPAGES = 2;

  // Decoded access, brought out for the checker.
  logic             in_window;
  logic             acc_mapped;
  logic             acc_unmapped;
  logic             page_sel;
  logic [OFF_W-1:0] offset;
  logic [IDX_W-1:0] word_idx;
  logic [1:0]       lane;
  logic             wr_fire;
  logic             rd_fire;
  logic [3:0]       byte_en;
  logic [31:0]      lane_wdata;
  logic [NPAGES-1:0] page_we;
  logic [31:0]      page_q [NPAGES];

  ocram_decode #(
    .WIN_BASE(WIN_BASE), .WIN_END(WIN_END), .ALT_BIT(ALT_BIT), .OFF_W(OFF_W)
  ) u_dec (
    .addr(acc_addr), .index_split(cfg_index_split), .ram_on(cfg_ram_on),
    .cache_on(cfg_cache_on), .in_window(in_window), .mapped(acc_mapped),
    .page_sel(page_sel), .offset(offset)
  );

  assign acc_unmapped = acc_valid && in_window && !acc_mapped;
  assign wr_fire      = acc_valid && acc_mapped && acc_we;
  assign rd_fire      = acc_valid && acc_mapped && !acc_we;
  assign word_idx     = offset[OFF_W-1:2];
  assign lane         = offset[1:0];
  assign byte_en      = f_lane_mask(acc_size, lane);
  assign lane_wdata   = f_lane_data(acc_size, acc_wdata);

  for (genvar pg = 0; pg < NPAGES; pg++) begin : g_page
    assign page_we[pg] = wr_fire && (page_sel == pg[0]);
    ocram_page_ram #(.WORDS(WORDS)) u_ram (
      .clk(clk), .we(page_we[pg]), .be(byte_en), .idx(word_idx),
      .wdata(lane_wdata), .re(rd_fire), .rdata(page_q[pg])
    );
  end

  // Response pipeline stage.
  logic       rv_q, err_q, page_q_sel, zero_q;
  logic [1:0] size_q, lane_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q       <= 1'b0;
      err_q      <= 1'b0;
      zero_q     <= 1'b1;
      page_q_sel <= 1'b0;
      size_q     <= SZ_LONG;
      lane_q     <= 2'd0;
    end else begin
      rv_q  <= acc_valid && in_window && !acc_we;
      err_q <= acc_unmapped;
      if (acc_valid && in_window && !acc_we) begin
        zero_q     <= !acc_mapped;
        page_q_sel <= page_sel;
        size_q     <= acc_size;
        lane_q     <= lane;
      end
    end
  end

  logic [31:0] fmt_data;
  ocram_rdfmt u_fmt (
    .size(size_q), .lane(lane_q), .word(page_q[page_q_sel]),
    .zero(zero_q || !rv_q), .data(fmt_data)
  );

  assign rd_valid = rv_q;
  assign rd_data  = fmt_data;
  assign acc_err  = err_q;
endmodule

// File: rtl/ocram_window_chk.sv
module ocram_window_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic [31:0] acc_addr,
  input logic [1:0]  acc_size,
  input logic        acc_we,
  input logic        cfg_index_split,
  input logic        cfg_ram_on,
  input logic        cfg_cache_on,
  input logic        rd_valid,
  input logic [31:0] rd_data,
  input logic        acc_err,
  input logic        in_window,
  input logic        page_sel,
  input logic        acc_unmapped,
  input logic [1:0]  page_we
);
  a_r1_outside_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !in_window) |=> (!rd_valid && !acc_err));

  a_r3_bit13_page: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && in_window && !cfg_index_split) |-> (page_sel == acc_addr[13]));

  a_r4_half_page: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && in_window && cfg_index_split) |-> (page_sel == acc_addr[25]));

  a_r5_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> $past(acc_valid && in_window && !(cfg_ram_on && cfg_cache_on)));

  a_r5_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && acc_err) |-> (rd_data == 32'd0));

  a_r5_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    acc_unmapped |-> (page_we == 2'b00));

  a_r6_answer: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && in_window && !acc_we) |=> rd_valid);

  a_r6_source: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(acc_valid && in_window && !acc_we));

  a_r7_byte_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(acc_size) == 2'd0) |-> (rd_data[31:8] == {24{rd_data[7]}}));

  a_r8_word_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(acc_size) == 2'd1) |-> (rd_data[31:16] == {16{rd_data[15]}}));

  a_r10_one_page: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(page_we));
endmodule

bind ocram_window ocram_window_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_size(acc_size), .acc_we(acc_we), .cfg_index_split(cfg_index_split),
  .cfg_ram_on(cfg_ram_on), .cfg_cache_on(cfg_cache_on), .rd_valid(rd_valid),
  .rd_data(rd_data), .acc_err(acc_err), .in_window(in_window),
  .page_sel(page_sel), .acc_unmapped(acc_unmapped), .page_we(page_we)
);

// File: tb/ocram_window_tb.sv
module ocram_window_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic        acc_we = 1'b0;
  logic [31:0] acc_wdata = '0;
  logic        cfg_index_split = 1'b0;
  logic        cfg_ram_on = 1'b1;
  logic        cfg_cache_on = 1'b1;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        acc_err;

  always #10 clk = ~clk;

  ocram_window u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_we(acc_we), .acc_wdata(acc_wdata),
    .cfg_index_split(cfg_index_split), .cfg_ram_on(cfg_ram_on),
    .cfg_cache_on(cfg_cache_on), .rd_valid(rd_valid), .rd_data(rd_data),
    .acc_err(acc_err)
  );

  int    n_checks = 0;
  int    n_fail = 0;
  string cur_req = "R6";

  // Behavioural reference: 8 KiB of bytes, page p at p*4096.
  logic [7:0]  mdl [8192];
  logic        exp_rv = 1'b0, exp_err = 1'b0;
  logic [31:0] exp_data = '0;
  string       exp_req = "R6";

  function automatic int loc(input logic [31:0] a, input logic split);
    int pg;
    pg = split ? ((a >= 32'h7E00_0000) ? 1 : 0) : int'(a[13]);
    return pg * 4096 + int'(a[11:0]);
  endfunction

  function automatic bit in_win(input logic [31:0] a);
    return (a >= 32'h7C00_0000) && (a <= 32'h7FFF_FFFF);
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      exp_rv   <= 1'b0;
      exp_err  <= 1'b0;
      exp_data <= '0;
      exp_req  <= cur_req;
      if (acc_valid && in_win(acc_addr)) begin
        if (!(cfg_ram_on && cfg_cache_on)) begin
          exp_err <= 1'b1;
          exp_rv  <= !acc_we;
        end else begin
          int l;
          l = loc(acc_addr, cfg_index_split);
          if (acc_we) begin
            if (acc_size == 2'd0) mdl[l] = acc_wdata[7:0];
            else if (acc_size == 2'd1) begin
              l = l & ~1;
              mdl[l] = acc_wdata[7:0]; mdl[l+1] = acc_wdata[15:8];
            end else begin
              l = l & ~3;
              for (int k = 0; k < 4; k++) mdl[l+k] = acc_wdata[8*k +: 8];
            end
          end else begin
            exp_rv <= 1'b1;
            if (acc_size == 2'd0) exp_data <= 32'($signed(mdl[l]));
            else if (acc_size == 2'd1) begin
              l = l & ~1;
              exp_data <= 32'($signed({mdl[l+1], mdl[l]}));
            end else begin
              l = l & ~3;
              exp_data <= {mdl[l+3], mdl[l+2], mdl[l+1], mdl[l]};
            end
          end
        end
      end
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      n_checks++;
      if (rd_valid !== exp_rv || acc_err !== exp_err ||
          (exp_rv && rd_data !== exp_data)) begin
        n_fail++;
        $display("FAIL %s: rv/err/data = %0b/%0b/%08h expected %0b/%0b/%08h",
                 exp_req, rd_valid, acc_err, rd_data, exp_rv, exp_err, exp_data);
      end
    end
  end

  task automatic acc(input logic [31:0] a, input logic [1:0] sz, input logic we,
                     input logic [31:0] wd);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_size = sz; acc_we = we; acc_wdata = wd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      acc_valid = 1'b0; acc_we = 1'b0;
    end
  endtask

  task automatic cfg(input logic split, input logic ram, input logic cen);
    idle(1);
    cfg_index_split = split; cfg_ram_on = ram; cfg_cache_on = cen;
    idle(1);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run still active, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6: reset state
    n_checks++;
    if (rd_valid !== 1'b0 || acc_err !== 1'b0) begin
      n_fail++;
      $display("FAIL R6: after reset rv/err = %0b/%0b expected 0/0", rd_valid, acc_err);
    end

    // Fill both pages through the bit-13 mapping (R10 longword writes).
    cur_req = "R10";
    for (int i = 0; i < 1024; i++) acc(32'h7C00_0000 + 32'(i*4), 2'd2, 1'b1, 32'hA500_0000 + 32'(i));
    for (int i = 0; i < 1024; i++) acc(32'h7C00_2000 + 32'(i*4), 2'd2, 1'b1, 32'h5A00_0000 + 32'(i));
    idle(1);

    cur_req = "R3";
    acc(32'h7C00_0010, 2'd2, 1'b0, 0);
    acc(32'h7C00_2010, 2'd2, 1'b0, 0);
    acc(32'h7C00_2010, 2'd0, 1'b1, 32'h77);
    acc(32'h7C00_0010, 2'd2, 1'b0, 0);
    acc(32'h7C00_6010, 2'd2, 1'b0, 0);

    cur_req = "R4";
    cfg(1'b1, 1'b1, 1'b1);
    acc(32'h7C00_0010, 2'd2, 1'b0, 0);
    acc(32'h7C00_2010, 2'd2, 1'b0, 0);
    acc(32'h7E00_0010, 2'd2, 1'b0, 0);
    acc(32'h7DFF_FFFC, 2'd2, 1'b0, 0);
    acc(32'h7FFF_E010, 2'd2, 1'b0, 0);

    cur_req = "R2";
    cfg(1'b0, 1'b1, 1'b1);
    acc(32'h7C00_4FFC, 2'd2, 1'b1, 32'hCAFE_F00D);
    acc(32'h7C00_0FFC, 2'd2, 1'b0, 0);
    acc(32'h7F01_8FFC, 2'd2, 1'b0, 0);

    cur_req = "R7";
    acc(32'h7C00_0100, 2'd2, 1'b1, 32'h80FF_7F01);
    for (int b = 0; b < 4; b++) acc(32'h7C00_0100 + 32'(b), 2'd0, 1'b0, 0);

    cur_req = "R8";
    acc(32'h7C00_0104, 2'd2, 1'b1, 32'h7FFF_8001);
    for (int b = 0; b < 4; b++) acc(32'h7C00_0104 + 32'(b), 2'd1, 1'b0, 0);

    cur_req = "R9";
    for (int b = 0; b < 4; b++) acc(32'h7C00_0100 + 32'(b), 2'd2, 1'b0, 0);
    acc(32'h7C00_0105, 2'd3, 1'b0, 0);

    cur_req = "R10";
    acc(32'h7C00_0200, 2'd2, 1'b1, 32'h1122_3344);
    acc(32'h7C00_0202, 2'd0, 1'b1, 32'hFFFF_FFAB);
    acc(32'h7C00_0201, 2'd1, 1'b1, 32'hFFFF_CDEF);
    acc(32'h7C00_0200, 2'd2, 1'b0, 0);
    acc(32'h7C00_0203, 2'd1, 1'b1, 32'h0000_9876);
    acc(32'h7C00_0200, 2'd2, 1'b0, 0);

    cur_req = "R11";
    for (int i = 0; i < 8; i++) begin
      acc(32'h7C00_2300 + 32'(i*4), 2'd2, 1'b1, 32'h0BAD_0000 + 32'(i));
      acc(32'h7C00_2300 + 32'(i*4), 2'd2, 1'b0, 0);
    end

    cur_req = "R5";
    cfg(1'b0, 1'b0, 1'b1);
    acc(32'h7C00_0300, 2'd2, 1'b0, 0);
    acc(32'h7C00_0300, 2'd2, 1'b1, 32'hDEAD_BEEF);
    acc(32'h7C00_0300, 2'd2, 1'b1, 32'hDEAD_BEEF);
    cfg(1'b1, 1'b1, 1'b0);
    acc(32'h7E00_0300, 2'd0, 1'b0, 0);
    acc(32'h7E00_0300, 2'd2, 1'b1, 32'hDEAD_BEEF);
    cfg(1'b0, 1'b1, 1'b1);
    acc(32'h7C00_0300, 2'd2, 1'b0, 0);
    acc(32'h7C00_2300, 2'd2, 1'b0, 0);

    cur_req = "R1";
    acc(32'h8000_0000, 2'd2, 1'b1, 32'h1234_5678);
    acc(32'h7BFF_F000, 2'd2, 1'b1, 32'h1234_5678);
    acc(32'h8000_0000, 2'd2, 1'b0, 0);
    acc(32'h7BFF_FFFC, 2'd0, 1'b0, 0);
    acc(32'h7C00_0000, 2'd2, 1'b0, 0);
    acc(32'h7C00_1000, 2'd2, 1'b0, 0);

    cur_req = "R6";
    idle(4);
    acc(32'h7C00_0000, 2'd2, 1'b0, 0);
    idle(3);

    // Mixed traffic over the whole window and its edges.
    cur_req = "R2";
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a;
      logic [1:0]  sz;
      logic        w;
      if (i % 500 == 0) cfg(1'($urandom), ($urandom % 5) != 0, ($urandom % 5) != 0);
      a  = 32'h7C00_0000 + ($urandom & 32'h03FF_FFFF);
      if ($urandom % 16 == 0) a = a ^ 32'hC000_0000;
      sz = 2'($urandom);
      w  = 1'($urandom);
      acc(a, sz, w, $urandom);
    end
    idle(3);
    finish_run();
  end
endmodule